// File: doc/BRIEF.md
# Divider-Tap Clock Timer with Interrupts

This block is a timekeeping peripheral. It keeps a 7-bit binary counter that advances once for each single-cycle 256 Hz enable pulse from an upstream divider. Its stages therefore toggle at 128, 64, 32, 16, 8, 4 and 2 Hz. Everything runs on the system clock: there is no derived clock, and the 256 Hz input is only an enable.

Software reads the four slowest stages through a small register port. When the 32 Hz, 8 Hz or 2 Hz stage drops from 1 to 0, the block latches a cause flag. Each flag has its own enable bit, and a single request line is high while any enabled flag is set. Reading the flag register returns the flags and clears them. A separate counter clear input restarts the count and leaves the flags and enables alone.

Register map: address 0 is the stage view (read-only), address 1 holds the interrupt enables (read/write), address 2 holds the cause flags (read clears), and address 3 is unused.

Top module: `divtap_timer`

## Requirements
- R1: After a synchronous reset the counter, the cause flags and the enable bits are all zero, and `irq` is low.
- R2: Each cycle with `tick_256` high and `cnt_clr` low advances the counter by one, wrapping from 127 to 0. Without a tick the counter holds.
- R3: A read of address 0 returns the 16 Hz stage in bit 0, 8 Hz in bit 1, 4 Hz in bit 2 and 2 Hz in bit 3. These are counter bits 3 to 6.
- R4: A cause flag is set on the same clock edge at which an increment takes its stage from 1 to 0. The 32 Hz stage is counter bit 2, the 8 Hz stage is bit 4 and the 2 Hz stage is bit 6. The flags read at address 2 as bit 0 = 32 Hz, bit 1 = 8 Hz and bit 2 = 2 Hz.
- R5: A cause flag is set by its event whatever the state of its enable bit.
- R6: `irq` is high exactly while some flag is set together with its enable bit.
- R7: A read of address 2 returns the flags and clears them on that clock edge. An event on that same edge leaves its flag set.
- R8: Address 1 holds the enables in bits 0 to 2, in the same order as the flags. A write stores `bus_wdata[2:0]` and a read returns it.
- R9: Writes to address 0 and address 2 change neither the counter nor the flags.
- R10: `cnt_clr` zeroes the counter, takes priority over a tick on the same cycle, raises no event, and leaves the flags and enables unchanged.
- R11: `bus_rdata` is zero when there is no read access, and when the read is to address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_256 | input | 1 | Single-cycle 256 Hz count enable |
| cnt_clr | input | 1 | Counter clear |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data, combinational during a read |
| irq | output | 1 | Combined interrupt request |

## Verification
A counter that is off by one shows up at once in the stage view. It also moves every event by whole ticks, so the flag reads and `irq` disagree with the reference model within one 32 Hz period, which is 8 ticks. A lost or extra flag bit is visible on the next flag read, or on `irq` in the same cycle if its enable is set. A clear-on-read that overrides a same-edge event is caught by a read deliberately placed on the event edge. The bench compares the read data and `irq` against its model on every clock, so any difference is reported in the cycle it first appears.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CNT_W_DEF  = 7;
    localparam int VIEW_W_DEF = 4;
    localparam int NUM_EV_DEF = 3;
    localparam int DATA_W_DEF = 4;

    typedef enum logic [1:0] {
        REG_STAGES = 2'd0,
        REG_ENABLE = 2'd1,
        REG_CAUSE  = 2'd2,
        REG_SPARE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     rd;
        logic     wr;
        reg_sel_e sel;
    } bus_req_t;

    // Counter bit whose falling edge raises event i: 2 (32 Hz), 4 (8 Hz), 6 (2 Hz)
    function automatic int ev_tap(input int i);
        return 2 + 2 * i;
    endfunction

endpackage

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int CNT_W  = CNT_W_DEF,
    parameter int NUM_EV = NUM_EV_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              clr,
    output logic [CNT_W-1:0]  cnt,
    output logic [NUM_EV-1:0] ev
);

    logic advance;
    assign advance = tick & ~clr;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // A stage falls on the increment that carries through all bits up to it
    for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
        localparam int TAP = ev_tap(i);
        assign ev[i] = advance & (&cnt[TAP:0]);
    end

endmodule

// File: rtl/tmr_flags.sv
module tmr_flags #(
    parameter int NUM_EV = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_EV-1:0] ev,
    input  logic              cause_rd,
    input  logic              enable_we,
    input  logic [NUM_EV-1:0] enable_wdata,
    output logic [NUM_EV-1:0] flags,
    output logic [NUM_EV-1:0] enable,
    output logic              irq
);

    logic [NUM_EV-1:0] kept;
    assign kept = cause_rd ? '0 : flags;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags  <= '0;
            enable <= '0;
        end else begin
            flags <= kept | ev;
            if (enable_we) begin
                enable <= enable_wdata;
            end
        end
    end

    assign irq = |(flags & enable);

endmodule

// File: rtl/tmr_regbank.sv
module tmr_regbank
    import tmr_pkg::*;
#(
    parameter int VIEW_W = VIEW_W_DEF,
    parameter int NUM_EV = NUM_EV_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  bus_req_t           req,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [VIEW_W-1:0]  stages,
    input  logic [NUM_EV-1:0]  enable,
    input  logic [NUM_EV-1:0]  flags,
    output logic [DATA_W-1:0]  rdata,
    output logic               cause_rd,
    output logic               enable_we,
    output logic [NUM_EV-1:0]  enable_wdata
);

    localparam int PAD_EV = DATA_W - NUM_EV;
    localparam int PAD_VW = DATA_W - VIEW_W;

    logic unused_wbits;
    assign unused_wbits = ^wdata[DATA_W-1:NUM_EV];

    assign cause_rd     = req.rd && (req.sel == REG_CAUSE);
    assign enable_we    = req.wr && (req.sel == REG_ENABLE);
    assign enable_wdata = wdata[NUM_EV-1:0];

    always_comb begin
        rdata = '0;
        if (req.rd) begin
            unique case (req.sel)
                REG_STAGES: rdata = {{PAD_VW{1'b0}}, stages};
                REG_ENABLE: rdata = {{PAD_EV{1'b0}}, enable};
                REG_CAUSE:  rdata = {{PAD_EV{1'b0}}, flags};
                REG_SPARE:  rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/divtap_timer.sv
module divtap_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W  = CNT_W_DEF,
    parameter int VIEW_W = VIEW_W_DEF,
    parameter int NUM_EV = NUM_EV_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_256,
    input  logic              cnt_clr,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    logic [CNT_W-1:0]  cnt_q;
    logic [NUM_EV-1:0] ev;
    logic [NUM_EV-1:0] flags_q;
    logic [NUM_EV-1:0] enable_q;
    logic              cause_rd;
    logic              enable_we;
    logic [NUM_EV-1:0] enable_wdata;
    bus_req_t          req;

    assign req.rd  = bus_sel & ~bus_wr;
    assign req.wr  = bus_sel & bus_wr;
    assign req.sel = reg_sel_e'(bus_addr);

    tmr_counter #(.CNT_W(CNT_W), .NUM_EV(NUM_EV)) u_counter (
        .clk  (clk),
        .rst  (rst),
        .tick (tick_256),
        .clr  (cnt_clr),
        .cnt  (cnt_q),
        .ev   (ev)
    );

    tmr_flags #(.NUM_EV(NUM_EV)) u_flags (
        .clk          (clk),
        .rst          (rst),
        .ev           (ev),
        .cause_rd     (cause_rd),
        .enable_we    (enable_we),
        .enable_wdata (enable_wdata),
        .flags        (flags_q),
        .enable       (enable_q),
        .irq          (irq)
    );

    tmr_regbank #(.VIEW_W(VIEW_W), .NUM_EV(NUM_EV), .DATA_W(DATA_W)) u_regs (
        .req          (req),
        .wdata        (bus_wdata),
        .stages       (cnt_q[CNT_W-1 -: VIEW_W]),
        .enable       (enable_q),
        .flags        (flags_q),
        .rdata        (bus_rdata),
        .cause_rd     (cause_rd),
        .enable_we    (enable_we),
        .enable_wdata (enable_wdata)
    );

endmodule

// File: rtl/divtap_timer_chk.sv
module divtap_timer_chk #(
    parameter int CNT_W  = 7,
    parameter int NUM_EV = 3,
    parameter int DATA_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              cnt_clr,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [CNT_W-1:0]  cnt,
    input logic [NUM_EV-1:0] ev,
    input logic [NUM_EV-1:0] flags,
    input logic [NUM_EV-1:0] enable
);

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_clr) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    // R10
    cnt_clr_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_clr |=> (cnt == '0));

    // R4
    ev_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (ev != '0) |=> ((flags & $past(ev)) == $past(ev)));

    // R4
    flag_cause_chk: assert property (@(posedge clk) disable iff (rst)
        ((flags & ~$past(flags) & ~$past(ev)) == '0));

    // R7
    rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && bus_addr == 2'd2) |=> (flags == $past(ev)));

    // R8
    enable_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == 2'd1) |=> (enable == $past(bus_wdata[NUM_EV-1:0])));

    logic unused_hi;
    assign unused_hi = ^bus_wdata[DATA_W-1:NUM_EV];

endmodule

bind divtap_timer divtap_timer_chk #(.CNT_W(CNT_W), .NUM_EV(NUM_EV), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick_256),
    .cnt_clr   (cnt_clr),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cnt       (cnt_q),
    .ev        (ev),
    .flags     (flags_q),
    .enable    (enable_q)
);

// File: tb/test_divtap_timer.sv
`timescale 1ns/1ps
module test_divtap_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_256 = 1'b0;
    logic       cnt_clr = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [3:0] bus_wdata = 4'd0;
    logic [3:0] bus_rdata;
    logic       irq;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    done     = 0;
    int    m_cnt    = 0;
    int    m_flags  = 0;
    int    m_mask   = 0;
    string tag      = "R1";

    always #2 clk = ~clk;

    divtap_timer i_divtap_timer (
        .clk       (clk),
        .rst       (rst),
        .tick_256  (tick_256),
        .cnt_clr   (cnt_clr),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    function automatic int exp_rdata(input bit sel, input bit wr, input int addr);
        if (!sel || wr) return 0;
        case (addr)
            0: return (m_cnt >> 3) & 15;
            1: return m_mask;
            2: return m_flags;
            default: return 0;
        endcase
    endfunction

    // One clock: drive after falling edge, compare, then advance the model at the rising edge
    task automatic step(input bit tk, input bit clr, input bit sel, input bit wr,
                        input int addr, input int wd);
        int ev;
        @(negedge clk);
        tick_256  = tk;
        cnt_clr   = clr;
        bus_sel   = sel;
        bus_wr    = wr;
        bus_addr  = 2'(addr);
        bus_wdata = 4'(wd);
        #1;
        if (sel && !wr) begin
            if (addr == 0)      check("R3", "stage view", int'(bus_rdata), exp_rdata(sel, wr, addr));
            else if (addr == 1) check("R8", "enable read", int'(bus_rdata), exp_rdata(sel, wr, addr));
            else if (addr == 2) check("R7", "cause read", int'(bus_rdata), exp_rdata(sel, wr, addr));
            else                check("R11", "spare read", int'(bus_rdata), 0);
        end else begin
            check("R11", "idle rdata", int'(bus_rdata), 0);
        end
        check(tag, "irq", int'(irq), ((m_flags & m_mask) != 0) ? 1 : 0);
        @(posedge clk);
        ev = 0;
        if (tk && !clr) begin
            if (m_cnt % 8 == 7)   ev |= 1;
            if (m_cnt % 32 == 31) ev |= 2;
            if (m_cnt == 127)     ev |= 4;
        end
        if (sel && !wr && addr == 2) m_flags = 0;
        m_flags |= ev;
        if (sel && wr && addr == 1) m_mask = wd & 7;
        if (clr)     m_cnt = 0;
        else if (tk) m_cnt = (m_cnt + 1) % 128;
    endtask

    task automatic idle(input bit tk);
        step(tk, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_fails++;
            $display("FAIL R1 watchdog: actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int lfsr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: state after reset
        tag = "R1";
        step(0, 0, 1, 0, 0, 0);
        step(0, 0, 1, 0, 1, 0);
        step(0, 0, 1, 0, 2, 0);
        check("R1", "irq after reset", int'(irq), 0);

        // R5: an event with its enable clear still latches
        tag = "R5";
        for (int i = 0; i < 8; i++) idle(1);
        check("R5", "irq masked", int'(irq), 0);
        step(0, 0, 1, 0, 2, 0);
        check("R5", "flag model", m_flags, 0);

        // R6: a pending flag drives irq once its enable is set
        tag = "R6";
        for (int i = 0; i < 8; i++) idle(1);
        step(0, 0, 1, 1, 1, 1);
        idle(0);
        check("R6", "irq enabled", int'(irq), 1);
        step(0, 0, 1, 0, 2, 0);
        idle(0);
        check("R6", "irq after clear", int'(irq), 0);

        // R8: enable register write and read-back
        tag = "R8";
        step(0, 0, 1, 1, 1, 4'hD);
        step(0, 0, 1, 0, 1, 0);
        step(0, 0, 1, 1, 1, 7);
        step(0, 0, 1, 0, 1, 0);

        // R2 / R3: sparse ticks through more than two wraps
        tag = "R2";
        for (int i = 0; i < 600; i++) step(i % 2 == 0, 0, 1, 0, 0, 0);

        // R7: clearing read on the same edge as an event keeps the flag
        tag = "R7";
        step(0, 0, 1, 0, 2, 0);
        while (m_cnt % 8 != 7) idle(1);
        step(1, 0, 1, 0, 2, 0);
        check("R7", "flag after colliding read", m_flags & 1, 1);
        step(0, 0, 1, 0, 2, 0);

        // R9: writes to the view and cause registers are ignored
        tag = "R9";
        for (int i = 0; i < 8; i++) idle(1);
        step(0, 0, 1, 1, 0, 4'hF);
        step(0, 0, 1, 1, 2, 4'h0);
        step(0, 0, 1, 0, 0, 0);
        step(0, 0, 1, 0, 2, 0);

        // R10: clear beats a tick, raises no event, keeps flags and enables
        tag = "R10";
        while (m_cnt != 127) idle(1);
        step(1, 1, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0);
        check("R10", "model count", m_cnt, 0);
        for (int i = 0; i < 8; i++) idle(1);
        step(0, 1, 0, 0, 0, 0);
        step(0, 0, 1, 0, 1, 0);
        step(0, 0, 1, 0, 2, 0);

        // R11: spare address reads as zero
        tag = "R11";
        step(0, 0, 1, 0, 3, 0);
        step(1, 0, 1, 1, 3, 4'hF);

        // R4: pseudo-random mix of ticks, clears, reads and enable writes
        tag = "R4";
        lfsr = 32'h1ACE;
        for (int i = 0; i < 4000; i++) begin
            int r;
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
            r = lfsr & 16'hFFFF;
            step((r & 3) != 0, (r & 16'h3F0) == 16'h3F0, (r & 16'h30) != 0,
                 (r & 16'hC0) == 16'hC0, (r >> 8) & 3, (r >> 10) & 15);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule